// File: doc/BRIEF.md
# Hardware Task Switch Decision Unit

This block works out the bookkeeping that goes with a hardware task switch. A sequencer sets the switch kind (jump, call, interrupt or return-from-interrupt) on the inputs. It also supplies the type and limit of the incoming task-area descriptor, the selectors of both tasks, the two flag images, control register 0, and the I/O base and trap words already read from the incoming task area. It then pulses `start_i`. The unit captures these values and, one cycle later, reports its decisions. These are: which busy bits to clear or set, the adjusted outgoing and incoming flag images, whether and where to write the back-link, the new control register 0 image, the I/O permission window, a debug-trap request, and the addresses of the instruction-pointer, flags and local-descriptor-table-selector fields for the selected format.

Error cases produce no action. These are an unknown kind or descriptor type, a task area that is too short, and a return to a task that is not marked busy. The sequencer reads `done_o` and the error outputs to choose between committing the switch and raising a fault. The registers themselves are saved and restored by the sequencer, not by this unit.

Top module: `tsw_ctrl`

## Requirements
- R1: A `start_i` sampled high at clock edge N makes every decision output update at edge N+1 and `done_o` high for exactly the cycle after edge N+1. Between results the outputs hold their last values and `done_o` is low.
- R2: Kind codes are 0 jump, 1 call, 2 interrupt and 3 return; codes 4 to 7 are unknown. Descriptor types are 0x1 and 0x3 for the narrow format and 0x9 and 0xB for the wide format; any other type is unknown. An unknown kind or type sets `kind_err_o`. In that case every action output is low, the flag and control images pass through unchanged, `wide_o` is low, and the I/O window, trap and field addresses are zero.
- R3: A wide task with a limit below 0x67, or a narrow task with a limit below 0x2B, sets `fault_o` with `fault_sel_o` equal to the incoming selector, and takes no action. A limit exactly at the minimum is accepted.
- R4: A return clears flag bit 14 (nested task) in the outgoing image and raises `old_free_o`; the incoming image is unchanged and `new_busy_o` stays low.
- R5: A jump raises both `old_free_o` and `new_busy_o` and leaves both flag images unchanged.
- R6: A call or an interrupt raises `new_busy_o` and `link_we_o`, with `link_addr_o` equal to the incoming task base and `link_data_o` equal to the outgoing selector, and sets bit 14 in the incoming image. `old_free_o` stays low.
- R7: A return whose descriptor type has bit 1 (busy) clear sets `busy_err_o` and takes no action.
- R8: Every accepted switch sets bit 3 (task switched) of `cr0_o`; the other bits of control register 0 pass through.
- R9: For an accepted wide task with a nonzero I/O base strictly below the limit, `io_lim_o` is the limit minus the base, truncated to 16 bits, and `io_addr_o` is the task base plus the I/O base. In every other case both are zero.
- R10: `dbg_trap_o` equals bit 0 of the trap word for an accepted wide task and is zero otherwise.
- R11: For an accepted switch, `wide_o` gives the format. The field addresses are the task base plus 32, 36 and 96 (wide) or 14, 16 and 42 (narrow), for the instruction pointer, the flags and the local-table selector.
- R12: Errors are ranked as unknown kind or type first, then the limit fault, then the busy error. At most one error output is high.
- R13: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture the request inputs |
| kind_i | input | 3 | Switch kind code |
| dtype_i | input | 4 | Incoming descriptor type |
| new_sel_i | input | 16 | Incoming task selector |
| old_sel_i | input | 16 | Outgoing task selector |
| limit_i | input | 32 | Incoming task-area limit |
| base_i | input | 32 | Incoming task-area base |
| old_flags_i | input | 32 | Outgoing flag image |
| new_flags_i | input | 32 | Flag image read from the incoming area |
| iobase_i | input | 16 | I/O map base word from the incoming area |
| trap_i | input | 16 | Trap word from the incoming area |
| cr0_i | input | 32 | Current control register 0 |
| done_o | output | 1 | Result valid pulse |
| kind_err_o | output | 1 | Unknown kind or type |
| fault_o | output | 1 | Task area too short |
| fault_sel_o | output | 16 | Selector reported with the fault |
| busy_err_o | output | 1 | Return to a task not marked busy |
| wide_o | output | 1 | Wide format selected |
| old_free_o | output | 1 | Clear outgoing busy bit |
| new_busy_o | output | 1 | Set incoming busy bit |
| old_flags_o | output | 32 | Outgoing image to save |
| new_flags_o | output | 32 | Incoming image to load |
| link_we_o | output | 1 | Write back-link |
| link_addr_o | output | 32 | Back-link address |
| link_data_o | output | 16 | Back-link selector |
| cr0_o | output | 32 | New control register 0 |
| io_lim_o | output | 16 | I/O window length |
| io_addr_o | output | 32 | I/O window address |
| dbg_trap_o | output | 1 | Debug-trap request |
| ip_addr_o | output | 32 | Instruction pointer field address |
| flags_addr_o | output | 32 | Flags field address |
| ldt_addr_o | output | 32 | Local-table selector field address |

## Verification
The bench builds the block with its default parameters: flag bit 14, control bit 3, and minima 0x67 and 0x2B. Directed cases put limits one below and exactly at each minimum. They place the I/O base at zero, equal to the limit and just under it, and cover each kind with busy and free descriptor types, unknown codes combined with short limits, and back-to-back starts. A long run of random requests with limits kept near the minima then mixes all paths, with a reference model compared against every output on every clock.

// File: rtl/tsw_pkg.sv
package tsw_pkg;
    localparam int TSW_AW  = 32;
    localparam int TSW_SW  = 16;
    localparam int TSW_FW  = 32;
    localparam int TSW_IOW = 16;
    localparam int TSW_KW  = 3;
    localparam int TSW_TW  = 4;

    typedef enum logic [TSW_KW-1:0] {
        SW_JMP  = 3'd0,
        SW_CALL = 3'd1,
        SW_INTR = 3'd2,
        SW_IRET = 3'd3
    } sw_kind_e;

    localparam logic [TSW_TW-1:0] DT_NAR_FREE = 4'h1;
    localparam logic [TSW_TW-1:0] DT_NAR_BUSY = 4'h3;
    localparam logic [TSW_TW-1:0] DT_WID_FREE = 4'h9;
    localparam logic [TSW_TW-1:0] DT_WID_BUSY = 4'hB;
    localparam int DT_BUSY_BIT = 1;

    typedef struct packed {
        logic [TSW_KW-1:0]  kind;
        logic [TSW_TW-1:0]  dtype;
        logic [TSW_SW-1:0]  new_sel;
        logic [TSW_SW-1:0]  old_sel;
        logic [TSW_AW-1:0]  limit;
        logic [TSW_AW-1:0]  base;
        logic [TSW_FW-1:0]  old_flags;
        logic [TSW_FW-1:0]  new_flags;
        logic [TSW_IOW-1:0] iobase;
        logic [TSW_SW-1:0]  trap;
        logic [TSW_FW-1:0]  cr0;
    } tsw_req_t;

    typedef struct packed {
        logic               done;
        logic               kind_err;
        logic               fault;
        logic [TSW_SW-1:0]  fault_sel;
        logic               busy_err;
        logic               wide;
        logic               old_free;
        logic               new_busy;
        logic [TSW_FW-1:0]  old_flags;
        logic [TSW_FW-1:0]  new_flags;
        logic               link_we;
        logic [TSW_AW-1:0]  link_addr;
        logic [TSW_SW-1:0]  link_data;
        logic [TSW_FW-1:0]  cr0;
        logic [TSW_IOW-1:0] io_lim;
        logic [TSW_AW-1:0]  io_addr;
        logic               dbg_trap;
        logic [TSW_AW-1:0]  ip_addr;
        logic [TSW_AW-1:0]  flags_addr;
        logic [TSW_AW-1:0]  ldt_addr;
    } tsw_res_t;
endpackage

// File: rtl/tsw_fmt_dec.sv
module tsw_fmt_dec
    import tsw_pkg::*;
#(
    parameter int WIDE_MIN   = 32'h67,
    parameter int NARROW_MIN = 32'h2B
) (
    input  logic [TSW_TW-1:0] dtype_i,
    input  logic [TSW_AW-1:0] limit_i,
    output logic              type_ok_o,
    output logic              wide_o,
    output logic              marked_busy_o,
    output logic              limit_ok_o
);
    localparam logic [TSW_AW-1:0] WIDE_FLOOR   = TSW_AW'(WIDE_MIN);
    localparam logic [TSW_AW-1:0] NARROW_FLOOR = TSW_AW'(NARROW_MIN);

    always_comb begin
        type_ok_o = 1'b1;
        wide_o    = 1'b0;
        case (dtype_i)
            DT_NAR_FREE, DT_NAR_BUSY: wide_o = 1'b0;
            DT_WID_FREE, DT_WID_BUSY: wide_o = 1'b1;
            default:                  type_ok_o = 1'b0;
        endcase
    end

    assign marked_busy_o = dtype_i[DT_BUSY_BIT];
    assign limit_ok_o    = wide_o ? (limit_i >= WIDE_FLOOR) : (limit_i >= NARROW_FLOOR);
endmodule

// File: rtl/tsw_kind_mx.sv
module tsw_kind_mx
    import tsw_pkg::*;
(
    input  logic [TSW_KW-1:0] kind_i,
    output logic              kind_ok_o,
    output logic              free_old_o,
    output logic              busy_new_o,
    output logic              drop_old_nt_o,
    output logic              raise_new_nt_o,
    output logic              write_link_o,
    output logic              want_busy_o
);
    always_comb begin
        kind_ok_o      = 1'b1;
        free_old_o     = 1'b0;
        busy_new_o     = 1'b0;
        drop_old_nt_o  = 1'b0;
        raise_new_nt_o = 1'b0;
        write_link_o   = 1'b0;
        want_busy_o    = 1'b0;
        case (sw_kind_e'(kind_i))
            SW_JMP: begin
                free_old_o = 1'b1;
                busy_new_o = 1'b1;
            end
            SW_CALL, SW_INTR: begin
                busy_new_o     = 1'b1;
                raise_new_nt_o = 1'b1;
                write_link_o   = 1'b1;
            end
            SW_IRET: begin
                free_old_o    = 1'b1;
                drop_old_nt_o = 1'b1;
                want_busy_o   = 1'b1;
            end
            default: kind_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsw_io_win.sv
module tsw_io_win
    import tsw_pkg::*;
(
    input  logic               en_i,
    input  logic [TSW_IOW-1:0] iobase_i,
    input  logic [TSW_AW-1:0]  limit_i,
    input  logic [TSW_AW-1:0]  base_i,
    output logic [TSW_IOW-1:0] io_lim_o,
    output logic [TSW_AW-1:0]  io_addr_o
);
    logic [TSW_AW-1:0] iob_ext;
    logic [TSW_AW-1:0] span;
    logic              open_win;

    assign iob_ext  = TSW_AW'(iobase_i);
    assign span     = limit_i - iob_ext;
    assign open_win = en_i && (iobase_i != '0) && (iob_ext < limit_i);

    always_comb begin
        io_lim_o  = '0;
        io_addr_o = '0;
        if (open_win) begin
            io_lim_o  = span[TSW_IOW-1:0];
            io_addr_o = base_i + iob_ext;
        end
    end
endmodule

// File: rtl/tsw_ctrl.sv
module tsw_ctrl
    import tsw_pkg::*;
#(
    parameter int NT_BIT      = 14,
    parameter int TS_BIT      = 3,
    parameter int WIDE_MIN    = 32'h67,
    parameter int NARROW_MIN  = 32'h2B,
    parameter int WIDE_IP_OFS = 32,
    parameter int WIDE_FL_OFS = 36,
    parameter int WIDE_LD_OFS = 96,
    parameter int NAR_IP_OFS  = 14,
    parameter int NAR_FL_OFS  = 16,
    parameter int NAR_LD_OFS  = 42
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [TSW_KW-1:0]  kind_i,
    input  logic [TSW_TW-1:0]  dtype_i,
    input  logic [TSW_SW-1:0]  new_sel_i,
    input  logic [TSW_SW-1:0]  old_sel_i,
    input  logic [TSW_AW-1:0]  limit_i,
    input  logic [TSW_AW-1:0]  base_i,
    input  logic [TSW_FW-1:0]  old_flags_i,
    input  logic [TSW_FW-1:0]  new_flags_i,
    input  logic [TSW_IOW-1:0] iobase_i,
    input  logic [TSW_SW-1:0]  trap_i,
    input  logic [TSW_FW-1:0]  cr0_i,
    output logic               done_o,
    output logic               kind_err_o,
    output logic               fault_o,
    output logic [TSW_SW-1:0]  fault_sel_o,
    output logic               busy_err_o,
    output logic               wide_o,
    output logic               old_free_o,
    output logic               new_busy_o,
    output logic [TSW_FW-1:0]  old_flags_o,
    output logic [TSW_FW-1:0]  new_flags_o,
    output logic               link_we_o,
    output logic [TSW_AW-1:0]  link_addr_o,
    output logic [TSW_SW-1:0]  link_data_o,
    output logic [TSW_FW-1:0]  cr0_o,
    output logic [TSW_IOW-1:0] io_lim_o,
    output logic [TSW_AW-1:0]  io_addr_o,
    output logic               dbg_trap_o,
    output logic [TSW_AW-1:0]  ip_addr_o,
    output logic [TSW_AW-1:0]  flags_addr_o,
    output logic [TSW_AW-1:0]  ldt_addr_o
);
    localparam logic [TSW_FW-1:0] NT_MASK = TSW_FW'(1) << NT_BIT;
    localparam logic [TSW_FW-1:0] TS_MASK = TSW_FW'(1) << TS_BIT;

    typedef struct packed {
        logic     pend;
        tsw_req_t req;
        tsw_res_t res;
    } tsw_state_t;

    tsw_state_t st_d, st_q;

    logic type_ok, fmt_wide, marked_busy, limit_ok;
    logic kind_ok, free_old, busy_new, drop_old_nt, raise_new_nt, write_link, want_busy;
    logic accept;
    logic [TSW_IOW-1:0] win_lim;
    logic [TSW_AW-1:0]  win_addr;

    tsw_fmt_dec #(
        .WIDE_MIN   (WIDE_MIN),
        .NARROW_MIN (NARROW_MIN)
    ) fmt_i (
        .dtype_i       (st_q.req.dtype),
        .limit_i       (st_q.req.limit),
        .type_ok_o     (type_ok),
        .wide_o        (fmt_wide),
        .marked_busy_o (marked_busy),
        .limit_ok_o    (limit_ok)
    );

    tsw_kind_mx kmx_i (
        .kind_i         (st_q.req.kind),
        .kind_ok_o      (kind_ok),
        .free_old_o     (free_old),
        .busy_new_o     (busy_new),
        .drop_old_nt_o  (drop_old_nt),
        .raise_new_nt_o (raise_new_nt),
        .write_link_o   (write_link),
        .want_busy_o    (want_busy)
    );

    tsw_io_win iow_i (
        .en_i      (accept && fmt_wide),
        .iobase_i  (st_q.req.iobase),
        .limit_i   (st_q.req.limit),
        .base_i    (st_q.req.base),
        .io_lim_o  (win_lim),
        .io_addr_o (win_addr)
    );

    assign accept = kind_ok && type_ok && limit_ok && !(want_busy && !marked_busy);

    always_comb begin
        tsw_res_t r;
        st_d      = st_q;
        st_d.pend = start_i;
        if (start_i) begin
            st_d.req.kind      = kind_i;
            st_d.req.dtype     = dtype_i;
            st_d.req.new_sel   = new_sel_i;
            st_d.req.old_sel   = old_sel_i;
            st_d.req.limit     = limit_i;
            st_d.req.base      = base_i;
            st_d.req.old_flags = old_flags_i;
            st_d.req.new_flags = new_flags_i;
            st_d.req.iobase    = iobase_i;
            st_d.req.trap      = trap_i;
            st_d.req.cr0       = cr0_i;
        end

        r           = '0;
        r.done      = 1'b1;
        r.old_flags = st_q.req.old_flags;
        r.new_flags = st_q.req.new_flags;
        r.cr0       = st_q.req.cr0;
        if (!(kind_ok && type_ok)) begin
            r.kind_err = 1'b1;
        end else if (!limit_ok) begin
            r.fault     = 1'b1;
            r.fault_sel = st_q.req.new_sel;
            r.wide      = fmt_wide;
        end else if (!accept) begin
            r.busy_err = 1'b1;
            r.wide     = fmt_wide;
        end else begin
            r.wide     = fmt_wide;
            r.old_free = free_old;
            r.new_busy = busy_new;
            if (drop_old_nt)  r.old_flags = st_q.req.old_flags & ~NT_MASK;
            if (raise_new_nt) r.new_flags = st_q.req.new_flags | NT_MASK;
            r.link_we = write_link;
            if (write_link) begin
                r.link_addr = st_q.req.base;
                r.link_data = st_q.req.old_sel;
            end
            r.cr0      = st_q.req.cr0 | TS_MASK;
            r.io_lim   = win_lim;
            r.io_addr  = win_addr;
            r.dbg_trap = fmt_wide & st_q.req.trap[0];
            r.ip_addr    = st_q.req.base + TSW_AW'(fmt_wide ? WIDE_IP_OFS : NAR_IP_OFS);
            r.flags_addr = st_q.req.base + TSW_AW'(fmt_wide ? WIDE_FL_OFS : NAR_FL_OFS);
            r.ldt_addr   = st_q.req.base + TSW_AW'(fmt_wide ? WIDE_LD_OFS : NAR_LD_OFS);
        end

        if (st_q.pend) begin
            st_d.res = r;
        end else begin
            st_d.res.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o       = st_q.res.done;
    assign kind_err_o   = st_q.res.kind_err;
    assign fault_o      = st_q.res.fault;
    assign fault_sel_o  = st_q.res.fault_sel;
    assign busy_err_o   = st_q.res.busy_err;
    assign wide_o       = st_q.res.wide;
    assign old_free_o   = st_q.res.old_free;
    assign new_busy_o   = st_q.res.new_busy;
    assign old_flags_o  = st_q.res.old_flags;
    assign new_flags_o  = st_q.res.new_flags;
    assign link_we_o    = st_q.res.link_we;
    assign link_addr_o  = st_q.res.link_addr;
    assign link_data_o  = st_q.res.link_data;
    assign cr0_o        = st_q.res.cr0;
    assign io_lim_o     = st_q.res.io_lim;
    assign io_addr_o    = st_q.res.io_addr;
    assign dbg_trap_o   = st_q.res.dbg_trap;
    assign ip_addr_o    = st_q.res.ip_addr;
    assign flags_addr_o = st_q.res.flags_addr;
    assign ldt_addr_o   = st_q.res.ldt_addr;
endmodule

// File: rtl/tsw_ctrl_chk.sv
module tsw_ctrl_chk
    import tsw_pkg::*;
#(
    parameter int NT_BIT = 14,
    parameter int TS_BIT = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [TSW_SW-1:0]  new_sel_i,
    input logic               done_o,
    input logic               kind_err_o,
    input logic               fault_o,
    input logic [TSW_SW-1:0]  fault_sel_o,
    input logic               busy_err_o,
    input logic               wide_o,
    input logic               old_free_o,
    input logic               new_busy_o,
    input logic [TSW_FW-1:0]  old_flags_o,
    input logic [TSW_FW-1:0]  new_flags_o,
    input logic               link_we_o,
    input logic [TSW_FW-1:0]  cr0_o,
    input logic [TSW_IOW-1:0] io_lim_o
);
    logic any_err;
    assign any_err = kind_err_o || fault_o || busy_err_o;

    p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(start_i, 2));

    p_no_action_on_error_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && any_err) |-> !(old_free_o || new_busy_o || link_we_o));

    p_fault_selector_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o) |-> (fault_sel_o == $past(new_sel_i, 2)));

    p_return_drops_nt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && old_free_o && !new_busy_o) |-> !old_flags_o[NT_BIT]);

    p_link_with_nt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        link_we_o |-> (new_flags_o[NT_BIT] && new_busy_o && !old_free_o));

    p_ts_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !any_err) |-> cr0_o[TS_BIT]);

    p_io_wide_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (io_lim_o != '0) |-> wide_o);

    p_single_error_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kind_err_o, fault_o, busy_err_o}));
endmodule

bind tsw_ctrl tsw_ctrl_chk #(
    .NT_BIT (NT_BIT),
    .TS_BIT (TS_BIT)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .new_sel_i   (new_sel_i),
    .done_o      (done_o),
    .kind_err_o  (kind_err_o),
    .fault_o     (fault_o),
    .fault_sel_o (fault_sel_o),
    .busy_err_o  (busy_err_o),
    .wide_o      (wide_o),
    .old_free_o  (old_free_o),
    .new_busy_o  (new_busy_o),
    .old_flags_o (old_flags_o),
    .new_flags_o (new_flags_o),
    .link_we_o   (link_we_o),
    .cr0_o       (cr0_o),
    .io_lim_o    (io_lim_o)
);

// File: tb/tsw_ctrl_tb_top.sv
module tsw_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  kind_i = '0;
    logic [3:0]  dtype_i = '0;
    logic [15:0] new_sel_i = '0, old_sel_i = '0, iobase_i = '0, trap_i = '0;
    logic [31:0] limit_i = '0, base_i = '0, old_flags_i = '0, new_flags_i = '0, cr0_i = '0;

    logic        done_o, kind_err_o, fault_o, busy_err_o, wide_o, old_free_o, new_busy_o;
    logic        link_we_o, dbg_trap_o;
    logic [15:0] fault_sel_o, link_data_o, io_lim_o;
    logic [31:0] old_flags_o, new_flags_o, link_addr_o, cr0_o, io_addr_o;
    logic [31:0] ip_addr_o, flags_addr_o, ldt_addr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    tsw_ctrl dut_i (.*);

    typedef struct {
        int unsigned kind, dtype, nsel, osel, limit, base, oflags, nflags, iob, trap, cr0;
    } req_s;

    typedef struct {
        int unsigned done, kerr, fault, fsel, berr, wide, ofree, nbusy, oflags, nflags;
        int unsigned lwe, laddr, ldata, cr0, iolim, ioaddr, dbg, ipa, fla, lda;
    } res_s;

    res_s exp_r;
    req_s held;
    bit   pend = 0;

    function automatic res_s model(req_s v);
        res_s e;
        bit known, wide;
        int unsigned floor_v;
        e = '{default: 0};
        e.done = 1;
        e.oflags = v.oflags;
        e.nflags = v.nflags;
        e.cr0 = v.cr0;
        known = (v.dtype == 1 || v.dtype == 3 || v.dtype == 9 || v.dtype == 11) && v.kind <= 3;
        wide = (v.dtype == 9 || v.dtype == 11);
        floor_v = wide ? 32'h67 : 32'h2B;
        if (!known) begin
            e.kerr = 1;
        end else if (v.limit < floor_v) begin
            e.fault = 1; e.fsel = v.nsel; e.wide = wide;
        end else if (v.kind == 3 && v.dtype != 3 && v.dtype != 11) begin
            e.berr = 1; e.wide = wide;
        end else begin
            e.wide = wide;
            e.cr0 = v.cr0 | 32'h8;
            if (v.kind == 0) begin
                e.ofree = 1; e.nbusy = 1;
            end else if (v.kind == 3) begin
                e.ofree = 1; e.oflags = v.oflags & ~32'h4000;
            end else begin
                e.nbusy = 1; e.lwe = 1; e.laddr = v.base; e.ldata = v.osel;
                e.nflags = v.nflags | 32'h4000;
            end
            if (wide && v.iob != 0 && v.iob < v.limit) begin
                e.iolim = (v.limit - v.iob) & 32'hFFFF;
                e.ioaddr = v.base + v.iob;
            end
            e.dbg = wide ? (v.trap & 1) : 0;
            e.ipa = v.base + (wide ? 32 : 14);
            e.fla = v.base + (wide ? 36 : 16);
            e.lda = v.base + (wide ? 96 : 42);
        end
        return e;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_r = '{default: 0};
            pend = 0;
        end else begin
            exp_r.done = 0;
            if (pend) exp_r = model(held);
            pend = start_i;
            if (start_i) held = '{kind_i, dtype_i, new_sel_i, old_sel_i, limit_i, base_i,
                                  old_flags_i, new_flags_i, iobase_i, trap_i, cr0_i};
        end
    end

    task automatic chk(string tag, int unsigned act, int unsigned exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) if (!finished) begin
        chk("R1 done", done_o, exp_r.done);
        chk("R2 kind_err", kind_err_o, exp_r.kerr);
        chk("R3 fault", fault_o, exp_r.fault);
        chk("R3 fault_sel", fault_sel_o, exp_r.fsel);
        chk("R7 busy_err", busy_err_o, exp_r.berr);
        chk("R11 wide", wide_o, exp_r.wide);
        chk("R5 old_free", old_free_o, exp_r.ofree);
        chk("R5 new_busy", new_busy_o, exp_r.nbusy);
        chk("R4 old_flags", old_flags_o, exp_r.oflags);
        chk("R6 new_flags", new_flags_o, exp_r.nflags);
        chk("R6 link_we", link_we_o, exp_r.lwe);
        chk("R6 link_addr", link_addr_o, exp_r.laddr);
        chk("R6 link_data", link_data_o, exp_r.ldata);
        chk("R8 cr0", cr0_o, exp_r.cr0);
        chk("R9 io_lim", io_lim_o, exp_r.iolim);
        chk("R9 io_addr", io_addr_o, exp_r.ioaddr);
        chk("R10 dbg_trap", dbg_trap_o, exp_r.dbg);
        chk("R11 ip_addr", ip_addr_o, exp_r.ipa);
        chk("R11 flags_addr", flags_addr_o, exp_r.fla);
        chk("R11 ldt_addr", ldt_addr_o, exp_r.lda);
        chk("R12 one error", ($countones({kind_err_o, fault_o, busy_err_o}) <= 1), 1);
    end

    task automatic issue(int unsigned k, int unsigned t, int unsigned lim, int unsigned iob,
                         int unsigned trp, bit gap);
        @(negedge clk);
        start_i = 1'b1;
        kind_i = 3'(k);
        dtype_i = 4'(t);
        limit_i = lim;
        iobase_i = 16'(iob);
        trap_i = 16'(trp);
        new_sel_i = 16'($urandom);
        old_sel_i = 16'($urandom);
        base_i = $urandom;
        old_flags_i = $urandom;
        new_flags_i = $urandom;
        cr0_i = $urandom;
        if (gap) begin
            @(negedge clk);
            start_i = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #4000000;
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R13: outputs while reset is held
        chk("R13 reset done", done_o, 0);
        chk("R13 reset cr0", cr0_o, 0);
        chk("R13 reset flags", new_flags_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        issue(0, 11, 32'h67, 32'h60, 1, 1);     // R5 jump, wide at floor, io window R9
        issue(1, 1, 32'h2B, 5, 1, 1);           // R6 call narrow at floor, R10 off
        issue(2, 9, 32'h200, 0, 0, 1);          // R6 interrupt, io base zero
        issue(3, 11, 32'h100, 32'h100, 1, 1);   // R4 return, io base equal to limit
        issue(3, 9, 32'h100, 32'h20, 0, 1);     // R7 return to free task
        issue(3, 1, 32'h40, 0, 0, 1);           // R7 narrow
        issue(0, 9, 32'h66, 0, 0, 1);           // R3 one below wide floor
        issue(1, 3, 32'h2A, 0, 0, 1);           // R3 one below narrow floor
        issue(5, 11, 32'h10, 0, 0, 1);          // R12 unknown kind beats fault
        issue(0, 4'h5, 32'h300, 8, 0, 1);       // R2 unknown type
        issue(3, 9, 32'h10, 0, 0, 1);           // R12 fault beats busy error
        issue(0, 11, 32'h1_0010, 32'h8, 1, 1);  // R9 truncated window
        issue(1, 11, 32'h80, 1, 1, 0);          // R1 back-to-back starts
        issue(3, 3, 32'h80, 1, 1, 0);
        issue(2, 1, 32'h80, 1, 1, 1);
        for (int i = 0; i < 3000; i++) begin
            int unsigned tsel;
            tsel = $urandom_range(0, 9);
            issue($urandom_range(0, 5),
                  (tsel < 8) ? ((tsel % 4 == 0) ? 1 : (tsel % 4 == 1) ? 3 : (tsel % 4 == 2) ? 9 : 11)
                             : $urandom_range(0, 15),
                  $urandom_range(32'h20, 32'h140), $urandom_range(0, 32'h150),
                  $urandom, $urandom_range(0, 1) == 1);
        end
        @(negedge clk);
        start_i = 1'b0;
        repeat (4) @(negedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule